// File: doc/BRIEF.md
# Downstream Low-Speed Traffic Gate for a Hub Repeater

This block sits in the repeater of a hub with one upstream port and several downstream ports. It decides, one full-speed bit time at a time, which downstream ports carry the traffic arriving from upstream, and whether each of those ports uses its low-speed drivers. The input is an abstracted upstream line state sampled once per 12 MHz bit time. A separate decoder supplies a strobe on the bit time that carries the last bit of a PID, plus a flag that marks that PID as a preamble. Each downstream port also supplies two static flags: whether it is enabled, and whether a low-speed device was detected on it at attach time. That detection depends on which data line the device pulls high.

A packet that starts without a preamble is repeated only to enabled full-speed ports. Low-speed ports stay at the idle J state and are not driven. When a preamble PID is decoded, a short fixed delay of at most four bit times follows. The gate then switches the low-speed ports onto their low-speed drivers and repeats the following traffic to every enabled port, both low-speed and full-speed. An end-of-packet releases all ports again: the EOP is SE0 for at least one bit time followed by J, the closing J is still repeated, and the gate then returns to idle. Traffic repeated toward the upstream port always uses full-speed drivers.

Top module: `hub_ls_gate`

## Requirements
- R1: While reset is held and after its release with an idle (J) upstream line, every drive enable and every low-speed select is 0 and every downstream line output is J.
- R2: Line states are encoded on two bits: SE0 = 2'b00, J = 2'b01, K = 2'b10. A K on the upstream line while the gate is idle starts a packet. One clock edge later, every enabled full-speed port is driven and outputs that upstream symbol. From then on, each port output follows the upstream symbol with one clock of latency.
- R3: A port whose enable input is low at a clock edge is not driven after that edge, and its line output is J.
- R4: During a packet that carries no preamble, enabled low-speed ports are not driven and output J, and no low-speed select is raised.
- R5: A preamble strobe sampled at clock edge E0 during a full-speed packet raises the low-speed select of every enabled low-speed port at edge E0+LS_DELAY and not before. LS_DELAY is a parameter from 1 to 4, default 2.
- R6: While low-speed traffic is active, every enabled port, low-speed or full-speed, is driven with the upstream symbol. The low-speed select is high only on the low-speed ports.
- R7: An end-of-packet (at least MIN_SE0 bit times of SE0 followed by J) keeps the current drive set for the edge that repeats the J. At the next edge all drive enables and low-speed selects fall.
- R8: A PID strobe without the preamble flag has no effect. A preamble strobe while idle or while low-speed traffic is already active has no effect, and is not remembered for a later packet.
- R9: SE0, J or the illegal state 2'b11 on the upstream line while idle starts no packet, and no port is driven.
- R10: The upstream speed select output is always 0 (full speed).
- R11: Clearing a port's enable in the middle of a packet stops driving that port at the next clock edge. The other ports are unaffected.
- R12: Each downstream port has its own two-bit line output, so ports in different states show different line states in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock, one edge per full-speed bit |
| rst_n | input | 1 | Active-low synchronous reset |
| us_sym_i | input | 2 | Upstream line state for this bit time (SE0/J/K encoding) |
| pid_stb_i | input | 1 | Pulses on the bit time holding the last bit of a decoded PID |
| pid_pre_i | input | 1 | Qualifies pid_stb_i: the decoded PID is a preamble |
| port_en_i | input | N_PORTS | Per-port enabled flag |
| port_ls_i | input | N_PORTS | Per-port low-speed device flag |
| dn_drive_o | output | N_PORTS | Per-port output driver enable |
| dn_ls_sel_o | output | N_PORTS | Per-port low-speed driver select |
| dn_sym_o | output | 2*N_PORTS | Per-port line state to drive, port i at bits [2i+1:2i] |
| us_ls_sel_o | output | 1 | Upstream driver speed select, 1 = low speed |

## Verification
Every downstream output is registered once. A symbol or enable change is therefore seen exactly one edge after it is sampled. The low-speed select rises LS_DELAY edges after the edge that samples the preamble strobe, and the release follows one edge after the J that closes an EOP. The bench changes inputs on the falling edge and reads the outputs one time unit after each rising edge. Each step therefore checks the result of the symbol sampled at that edge. The preamble scenario checks the select both one edge before and at the edge where it is due, so that a rise that is early or late by one cycle is caught.

// File: rtl/hub_ls_gate_pkg.sv
package hub_ls_gate_pkg;

    // Two-bit line state encoding used on every symbol port
    typedef enum logic [1:0] {
        SYM_SE0 = 2'b00,
        SYM_J   = 2'b01,
        SYM_K   = 2'b10,
        SYM_SE1 = 2'b11
    } line_sym_e;

    // Repeater gate sequence
    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_FS_PKT   = 2'b01,
        ST_PRE_WAIT = 2'b10,
        ST_LS_ACT   = 2'b11
    } gate_st_e;

endpackage

// File: rtl/hub_ls_gate_eop.sv
module hub_ls_gate_eop
    import hub_ls_gate_pkg::*;
#(
    parameter int MIN_SE0 = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sym_i,
    output logic       eop_o
);
    localparam int SW = $clog2(MIN_SE0 + 1);

    typedef struct packed {
        logic [SW-1:0] se0_run;
    } eop_t;

    eop_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (line_sym_e'(sym_i) == SYM_SE0) begin
            if (cur_q.se0_run != SW'(MIN_SE0))
                nxt_d.se0_run = cur_q.se0_run + SW'(1);
        end else begin
            nxt_d.se0_run = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign eop_o = (cur_q.se0_run == SW'(MIN_SE0)) && (line_sym_e'(sym_i) == SYM_J);

    // R7
    eop_after_se0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eop_o |-> (line_sym_e'($past(sym_i)) == SYM_SE0));

endmodule

// File: rtl/hub_ls_gate_seq.sv
module hub_ls_gate_seq
    import hub_ls_gate_pkg::*;
#(
    parameter int LS_DELAY = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] sym_i,
    input  logic       eop_i,
    input  logic       pid_stb_i,
    input  logic       pid_pre_i,
    output logic       fs_fwd_o,
    output logic       ls_fwd_o,
    output logic [1:0] state_o
);
    localparam int CW = $clog2(LS_DELAY + 1);

    typedef struct packed {
        gate_st_e      st;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t cur_q, nxt_d;
    logic fs_fwd, ls_fwd;

    always_comb begin
        nxt_d  = cur_q;
        fs_fwd = 1'b0;
        ls_fwd = 1'b0;
        unique case (cur_q.st)
            ST_IDLE: begin
                if (line_sym_e'(sym_i) == SYM_K) begin
                    nxt_d.st = ST_FS_PKT;
                    fs_fwd   = 1'b1;
                end
            end
            ST_FS_PKT: begin
                fs_fwd = 1'b1;
                if (eop_i) begin
                    nxt_d.st = ST_IDLE;
                end else if (pid_stb_i && pid_pre_i) begin
                    nxt_d.st  = ST_PRE_WAIT;
                    nxt_d.cnt = CW'(LS_DELAY);
                end
            end
            ST_PRE_WAIT: begin
                fs_fwd = 1'b1;
                if (eop_i) begin
                    nxt_d.st  = ST_IDLE;
                    nxt_d.cnt = '0;
                end else if (cur_q.cnt <= CW'(1)) begin
                    nxt_d.st  = ST_LS_ACT;
                    nxt_d.cnt = '0;
                    ls_fwd    = 1'b1;
                end else begin
                    nxt_d.cnt = cur_q.cnt - CW'(1);
                end
            end
            ST_LS_ACT: begin
                fs_fwd = 1'b1;
                ls_fwd = 1'b1;
                if (eop_i) nxt_d.st = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.st  <= ST_IDLE;
            cur_q.cnt <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign fs_fwd_o = fs_fwd;
    assign ls_fwd_o = ls_fwd;
    assign state_o  = cur_q.st;

    // R5
    pre_cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_PRE_WAIT) |-> (cur_q.cnt != '0 && cur_q.cnt <= CW'(LS_DELAY)));

    // R5
    ls_entry_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.st == ST_LS_ACT && $past(cur_q.st) != ST_LS_ACT) |-> ($past(cur_q.st) == ST_PRE_WAIT));

endmodule

// File: rtl/hub_ls_gate_port.sv
module hub_ls_gate_port
    import hub_ls_gate_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       ls_i,
    input  logic       fs_fwd_i,
    input  logic       ls_fwd_i,
    input  logic [1:0] sym_i,
    output logic       drive_o,
    output logic       ls_sel_o,
    output logic [1:0] sym_o
);
    typedef struct packed {
        logic      drive;
        logic      ls_sel;
        line_sym_e sym;
    } port_t;

    port_t cur_q, nxt_d;
    logic  fwd;

    always_comb begin
        fwd          = ls_i ? ls_fwd_i : fs_fwd_i;
        nxt_d.drive  = en_i & fwd;
        nxt_d.ls_sel = en_i & fwd & ls_i;
        nxt_d.sym    = (en_i & fwd) ? line_sym_e'(sym_i) : SYM_J;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q.drive  <= 1'b0;
            cur_q.ls_sel <= 1'b0;
            cur_q.sym    <= SYM_J;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign drive_o  = cur_q.drive;
    assign ls_sel_o = cur_q.ls_sel;
    assign sym_o    = cur_q.sym;

    // R3
    disabled_port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> !cur_q.drive);

    // R12
    undriven_line_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_q.drive |-> (cur_q.sym == SYM_J));

endmodule

// File: rtl/hub_ls_gate.sv
module hub_ls_gate
    import hub_ls_gate_pkg::*;
#(
    parameter int N_PORTS  = 4,
    parameter int LS_DELAY = 2,
    parameter int MIN_SE0  = 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             us_sym_i,
    input  logic                   pid_stb_i,
    input  logic                   pid_pre_i,
    input  logic [N_PORTS-1:0]     port_en_i,
    input  logic [N_PORTS-1:0]     port_ls_i,
    output logic [N_PORTS-1:0]     dn_drive_o,
    output logic [N_PORTS-1:0]     dn_ls_sel_o,
    output logic [2*N_PORTS-1:0]   dn_sym_o,
    output logic                   us_ls_sel_o
);
    logic       eop_w;
    logic       fs_fwd_w;
    logic       ls_fwd_w;
    logic [1:0] state_w;

    hub_ls_gate_eop #(.MIN_SE0(MIN_SE0)) u_eop (
        .clk   (clk),
        .rst_n (rst_n),
        .sym_i (us_sym_i),
        .eop_o (eop_w)
    );

    hub_ls_gate_seq #(.LS_DELAY(LS_DELAY)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_i     (us_sym_i),
        .eop_i     (eop_w),
        .pid_stb_i (pid_stb_i),
        .pid_pre_i (pid_pre_i),
        .fs_fwd_o  (fs_fwd_w),
        .ls_fwd_o  (ls_fwd_w),
        .state_o   (state_w)
    );

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        hub_ls_gate_port u_port (
            .clk      (clk),
            .rst_n    (rst_n),
            .en_i     (port_en_i[p]),
            .ls_i     (port_ls_i[p]),
            .fs_fwd_i (fs_fwd_w),
            .ls_fwd_i (ls_fwd_w),
            .sym_i    (us_sym_i),
            .drive_o  (dn_drive_o[p]),
            .ls_sel_o (dn_ls_sel_o[p]),
            .sym_o    (dn_sym_o[2*p +: 2])
        );
    end

    // Upstream-bound repeating never uses the low-speed drivers
    assign us_ls_sel_o = 1'b0;

    // R7
    eop_closes_ls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eop_w |=> !ls_fwd_w);

    // R9
    idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_st_e'(state_w) == ST_IDLE && line_sym_e'(us_sym_i) != SYM_K) |=> (dn_drive_o == '0));

    // R5
    ls_rise_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|dn_ls_sel_o) |-> $past(ls_fwd_w));

endmodule

// File: tb/hub_ls_gate_tb.sv
module hub_ls_gate_tb;
    localparam int CLK_PERIOD = 10;
    localparam int N          = 4;
    localparam int LSD        = 2;

    localparam logic [1:0] SE0 = 2'b00;
    localparam logic [1:0] J   = 2'b01;
    localparam logic [1:0] K   = 2'b10;
    localparam logic [1:0] SE1 = 2'b11;

    // port0 FS enabled, port1 LS enabled, port2 FS disabled, port3 LS enabled
    localparam logic [N-1:0] EN_DEF = 4'b1011;
    localparam logic [N-1:0] LS_DEF = 4'b1010;
    localparam logic [N-1:0] FS_SET = 4'b0001;
    localparam logic [N-1:0] ALL_SET = 4'b1011;
    localparam logic [N-1:0] LS_SET = 4'b1010;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     us_sym = J;
    logic           pid_stb = 1'b0;
    logic           pid_pre = 1'b0;
    logic [N-1:0]   port_en = EN_DEF;
    logic [N-1:0]   port_ls = LS_DEF;
    logic [N-1:0]   dn_drive;
    logic [N-1:0]   dn_ls_sel;
    logic [2*N-1:0] dn_sym;
    logic           us_ls_sel;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hub_ls_gate #(.N_PORTS(N), .LS_DELAY(LSD), .MIN_SE0(1)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .us_sym_i    (us_sym),
        .pid_stb_i   (pid_stb),
        .pid_pre_i   (pid_pre),
        .port_en_i   (port_en),
        .port_ls_i   (port_ls),
        .dn_drive_o  (dn_drive),
        .dn_ls_sel_o (dn_ls_sel),
        .dn_sym_o    (dn_sym),
        .us_ls_sel_o (us_ls_sel)
    );

    function automatic logic [2*N-1:0] line_vec(input logic [N-1:0] drv, input logic [1:0] s);
        logic [2*N-1:0] v;
        for (int i = 0; i < N; i++) v[2*i +: 2] = drv[i] ? s : J;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic expect_out(input string tag, input logic [N-1:0] drv,
                              input logic [N-1:0] lss, input logic [1:0] s);
        chk({tag, " drive"}, 32'(dn_drive), 32'(drv));
        chk({tag, " ls_sel"}, 32'(dn_ls_sel), 32'(lss));
        chk({tag, " line"}, 32'(dn_sym), 32'(line_vec(drv, s)));
        chk("R10 upstream speed", 32'(us_ls_sel), 32'(0));
    endtask

    // Drive one bit time at the falling edge, then sample just after the rising edge
    task automatic step(input logic [1:0] s, input logic stb, input logic pre);
        @(negedge clk);
        us_sym  = s;
        pid_stb = stb;
        pid_pre = pre;
        @(posedge clk);
        #1;
    endtask

    task automatic go_idle();
        step(J, 1'b0, 1'b0);
        step(J, 1'b0, 1'b0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        expect_out("R1 in reset", '0, '0, J);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        expect_out("R1 after release", '0, '0, J);
    endtask

    task automatic t_idle_noise();
        step(SE0, 1'b0, 1'b0);
        expect_out("R9 idle SE0", '0, '0, J);
        step(J, 1'b0, 1'b0);
        expect_out("R9 idle J after SE0", '0, '0, J);
        step(SE1, 1'b0, 1'b0);
        expect_out("R9 idle SE1", '0, '0, J);
        go_idle();
    endtask

    task automatic t_fs_packet();
        step(K, 1'b0, 1'b0);
        expect_out("R2 R4 R3 start K", FS_SET, '0, K);
        step(J, 1'b0, 1'b0);
        expect_out("R2 R12 follow J", FS_SET, '0, J);
        step(K, 1'b1, 1'b0);
        expect_out("R8 non-preamble PID", FS_SET, '0, K);
        step(J, 1'b0, 1'b0);
        expect_out("R8 R4 no ls after plain PID", FS_SET, '0, J);
        step(J, 1'b0, 1'b0);
        expect_out("R4 still muted", FS_SET, '0, J);
        step(SE0, 1'b0, 1'b0);
        expect_out("R2 SE0 repeated", FS_SET, '0, SE0);
        step(J, 1'b0, 1'b0);
        expect_out("R7 closing J held", FS_SET, '0, J);
        step(J, 1'b0, 1'b0);
        expect_out("R7 released", '0, '0, J);
        go_idle();
    endtask

    task automatic t_preamble();
        step(K, 1'b0, 1'b0);
        step(J, 1'b0, 1'b0);
        step(K, 1'b1, 1'b1);
        expect_out("R5 strobe edge", FS_SET, '0, K);
        step(J, 1'b0, 1'b0);
        expect_out("R5 one edge early", FS_SET, '0, J);
        step(J, 1'b0, 1'b0);
        expect_out("R5 R6 ls drivers on", ALL_SET, LS_SET, J);
        step(K, 1'b0, 1'b0);
        expect_out("R6 R12 ls data K", ALL_SET, LS_SET, K);
        step(J, 1'b1, 1'b1);
        expect_out("R8 preamble while ls active", ALL_SET, LS_SET, J);
        step(SE0, 1'b0, 1'b0);
        expect_out("R6 SE0 repeated", ALL_SET, LS_SET, SE0);
        step(SE0, 1'b0, 1'b0);
        expect_out("R6 SE0 second", ALL_SET, LS_SET, SE0);
        step(J, 1'b0, 1'b0);
        expect_out("R7 ls closing J", ALL_SET, LS_SET, J);
        step(J, 1'b0, 1'b0);
        expect_out("R7 ls released", '0, '0, J);
        go_idle();
    endtask

    task automatic t_stale_preamble();
        step(J, 1'b1, 1'b1);
        expect_out("R8 preamble in idle", '0, '0, J);
        step(J, 1'b0, 1'b0);
        step(J, 1'b0, 1'b0);
        step(K, 1'b0, 1'b0);
        expect_out("R8 not remembered", FS_SET, '0, K);
        step(J, 1'b0, 1'b0);
        step(J, 1'b0, 1'b0);
        expect_out("R8 R4 still fs only", FS_SET, '0, J);
        step(SE0, 1'b0, 1'b0);
        step(J, 1'b0, 1'b0);
        step(J, 1'b0, 1'b0);
        expect_out("R7 stale end", '0, '0, J);
        go_idle();
    endtask

    task automatic t_enable_drop();
        step(K, 1'b0, 1'b0);
        expect_out("R11 before drop", FS_SET, '0, K);
        port_en = 4'b1010;
        step(K, 1'b0, 1'b0);
        expect_out("R11 R3 port0 dropped", '0, '0, K);
        port_en = EN_DEF;
        step(J, 1'b0, 1'b0);
        expect_out("R11 port0 restored", FS_SET, '0, J);
        step(SE0, 1'b0, 1'b0);
        step(J, 1'b0, 1'b0);
        step(J, 1'b0, 1'b0);
        expect_out("R7 drop end", '0, '0, J);
        go_idle();
    endtask

    task automatic t_ls_disabled_pre();
        port_en = 4'b0011;
        step(K, 1'b0, 1'b0);
        step(K, 1'b1, 1'b1);
        step(J, 1'b0, 1'b0);
        step(K, 1'b0, 1'b0);
        expect_out("R3 R6 disabled ls port skipped", 4'b0011, 4'b0010, K);
        step(SE0, 1'b0, 1'b0);
        step(J, 1'b0, 1'b0);
        step(J, 1'b0, 1'b0);
        expect_out("R7 end", '0, '0, J);
        port_en = EN_DEF;
        go_idle();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        go_idle();
        t_idle_noise();
        t_fs_packet();
        t_preamble();
        t_stale_preamble();
        t_enable_drop();
        t_ls_disabled_pre();
        finish_run();
    end

endmodule